// File: doc/BRIEF.md
# Byte-Port Command/Response Channel Controller

This block is the host-facing side of a single command/response channel. The host reaches it through a byte-wide register port. To prepare the channel it sets the command-ready flag. It then writes a command one byte at a time into a data window. When the status byte shows that no more bytes are expected, it sets the go flag. The controller then passes the buffered command to an execution engine over a valid/ready byte stream. It collects the engine's response bytes into the same byte buffer, and the host drains them through the data window.

Status is a handshake made of several flags, not full/empty indication. Burst count tells the host how many back-to-back data-window accesses it may make. An extended status byte reports the device family and carries a cancel control. Cancel takes effect only while a command is executing. When it does, the controller tells the engine to stop and substitutes a fixed "cancelled" response of its own. A retry control replays the current response from its first byte.

Top module: `cmdrsp_ctrl`

## Requirements
- R1: After reset the channel is idle. Status (0x18) reads 0x84: bit7 valid, bit2 self-test-done, all other bits 0. Burst count (0x19 low byte, 0x1A high byte) reads 0. Extended status (0x1B) reads 0x04, where bits[3:2]=01 is the 2.0 family and bit0 cancel reads 0.
- R2: Writing status bit6 (command-ready) while idle, ready or holding a response empties the buffer and enters Ready: status bit6 reads 1 and burst count equals the buffer depth. The same write while a command is being received or executed is ignored.
- R3: Bytes written to the data window (0x24 or its alias 0x80) are stored in order. While loading, burst count equals the free buffer space. Bytes beyond the buffer depth, and bytes written after the full command length has arrived, are dropped.
- R4: Status bit3 (expect) reads 1 while fewer than 6 bytes, or fewer than the big-endian 32-bit length held in command bytes 2..5, have arrived. Writing status bit5 (go) with expect at 0 starts execution. Go written while expect is 1 is ignored.
- R5: During execution the engine receives exactly the received command bytes, in order, with a last marker on the final byte. The engine's response bytes are then accepted until one is marked last.
- R6: While response bytes remain, status bit4 (data-available) reads 1 and burst count equals the remaining byte count. Each read of either data window returns the next response byte in order.
- R7: Writing status bit1 (retry) while a response is held restarts readout at the first response byte.
- R8: Writing extended-status bit0 (cancel) during execution pulses the engine abort output in the next cycle. The response then becomes the 10 bytes 80 01 00 00 00 0A 00 00 09 08.
- R9: Cancel written when no command is executing has no effect on state, readout position or the abort output.
- R10: Status bit7 (valid) reads 0 in the cycle after an accepted go or command-ready write, and 1 otherwise. Bit2 always reads 1.
- R11: If a cancel write and the engine's last response byte fall in the same cycle, the cancel wins and the cancelled response is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the data window) |
| bus_addr | input | AW (12) | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| eng_cmd_valid | output | 1 | Command byte to engine is valid |
| eng_cmd_ready | input | 1 | Engine accepts the command byte |
| eng_cmd_data | output | 8 | Command byte |
| eng_cmd_last | output | 1 | Final command byte |
| eng_rsp_valid | input | 1 | Response byte from engine is valid |
| eng_rsp_ready | output | 1 | Controller accepts a response byte |
| eng_rsp_data | input | 8 | Response byte |
| eng_rsp_last | input | 1 | Final response byte |
| eng_abort | output | 1 | One-cycle request for the engine to stop |

## Verification
The cancel control and the engine's final response byte can arrive in the same clock edge. One arrives as a register write and the other as a stream handshake, and each would move execution to the response phase with different contents. The bench drives the cancel write and the last-flagged response byte on the same falling edge. It then expects the abort pulse, a burst count of 10 and the fixed cancelled bytes on readout rather than the engine's data.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } cr_state_e;

  // Register byte addresses
  localparam logic [11:0] A_STS   = 12'h018;
  localparam logic [11:0] A_BC_LO = 12'h019;
  localparam logic [11:0] A_BC_HI = 12'h01A;
  localparam logic [11:0] A_XSTS  = 12'h01B;
  localparam logic [11:0] A_DATA  = 12'h024;
  localparam logic [11:0] A_XDATA = 12'h080;

  // Status bit positions
  localparam int B_VALID = 7;
  localparam int B_CRDY  = 6;
  localparam int B_GO    = 5;
  localparam int B_DAV   = 4;
  localparam int B_EXP   = 3;
  localparam int B_STDN  = 2;
  localparam int B_RETRY = 1;

  localparam int HDR_BYTES  = 6;
  localparam int CANCEL_LEN = 10;
  localparam logic [7:0] XSTS_FAMILY = 8'h04;

  // Byte idx of the substituted response after a cancel
  function automatic logic [7:0] cancel_byte(input int unsigned idx,
                                             input logic [31:0] rc);
    logic [7:0] b;
    case (idx)
      0:       b = 8'h80;
      1:       b = 8'h01;
      5:       b = 8'(CANCEL_LEN);
      6:       b = rc[31:24];
      7:       b = rc[23:16];
      8:       b = rc[15:8];
      9:       b = rc[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cmdrsp_buf.sv
module cmdrsp_buf #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [7:0]    rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [7:0]    rdata_b
);

  logic [7:0] mem_q [DEPTH];

  // Storage array: no reset, write enable spelled out
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  assign rdata_a = mem_q[ridx_a];
  assign rdata_b = mem_q[ridx_b];

endmodule

// File: rtl/cmdrsp_lenparse.sv
module cmdrsp_lenparse #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          byte_we,
  input  logic [CW-1:0] byte_idx,
  input  logic [7:0]    byte_in,
  output logic          expect_more
);
  import cmdrsp_pkg::*;

  localparam logic [CW-1:0] LEN_FIRST = CW'(2);
  localparam logic [CW-1:0] LEN_LAST  = CW'(5);
  localparam logic [CW-1:0] HDR_C     = CW'(HDR_BYTES);

  logic [31:0] len_q, len_d;

  always_comb begin
    len_d = len_q;
    if (clr) begin
      len_d = '0;
    end else if (byte_we && byte_idx >= LEN_FIRST && byte_idx <= LEN_LAST) begin
      len_d = {len_q[23:0], byte_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else begin
      len_q <= len_d;
    end
  end

  // byte_idx is the count of bytes already stored
  assign expect_more = (byte_idx < HDR_C) || (32'(byte_idx) < len_q);

endmodule

// File: rtl/cmdrsp_seq.sv
module cmdrsp_seq #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_crdy,
  input  logic                   req_go,
  input  logic                   req_retry,
  input  logic                   req_cancel,
  input  logic                   host_we,
  input  logic                   host_re,
  input  logic                   expect_more,
  input  logic                   eng_cmd_ready,
  input  logic                   eng_rsp_valid,
  input  logic                   eng_rsp_last,
  output cmdrsp_pkg::cr_state_e  st,
  output logic [CW-1:0]          wptr,
  output logic [CW-1:0]          sptr,
  output logic [CW-1:0]          rptr,
  output logic [CW-1:0]          rsp_len,
  output logic                   canned,
  output logic                   vhold,
  output logic                   abort_pls,
  output logic                   host_acc,
  output logic                   flush,
  output logic                   buf_we,
  output logic                   buf_from_eng,
  output logic [IW-1:0]          buf_widx,
  output logic                   cmd_valid,
  output logic                   cmd_last,
  output logic                   rsp_ready
);
  import cmdrsp_pkg::*;

  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
  localparam logic [CW-1:0] CANCEL_C = CW'(CANCEL_LEN);
  localparam logic [CW-1:0] ONE_C    = CW'(1);

  cr_state_e     st_q, st_d;
  logic [CW-1:0] wptr_q, wptr_d, sptr_q, sptr_d, rptr_q, rptr_d, rlen_q, rlen_d;
  logic          canned_q, canned_d, vhold_q, vhold_d, abort_q, abort_d;

  logic cmd_fire, rsp_fire, cancel_hit, crdy_hit, go_hit, retry_hit, rd_hit, rsp_store;

  assign cmd_valid  = (st_q == ST_EXEC) && (sptr_q < wptr_q);
  assign cmd_last   = cmd_valid && (sptr_q == wptr_q - ONE_C);
  assign rsp_ready  = (st_q == ST_EXEC) && (sptr_q == wptr_q);
  assign cmd_fire   = cmd_valid && eng_cmd_ready;
  assign rsp_fire   = rsp_ready && eng_rsp_valid;
  assign cancel_hit = req_cancel && (st_q == ST_EXEC);
  assign crdy_hit   = req_crdy && ((st_q == ST_IDLE) || (st_q == ST_READY) || (st_q == ST_DONE));
  assign go_hit     = req_go && (st_q == ST_RECV) && !expect_more;
  assign retry_hit  = req_retry && (st_q == ST_DONE) && !crdy_hit;
  assign rd_hit     = host_re && (st_q == ST_DONE) && (rptr_q < rlen_q);
  assign host_acc   = host_we && ((st_q == ST_READY) || ((st_q == ST_RECV) && expect_more))
                      && (wptr_q < DEPTH_C);
  assign rsp_store  = rsp_fire && !cancel_hit && (rlen_q < DEPTH_C);
  assign flush      = crdy_hit;

  assign buf_we       = host_acc || rsp_store;
  assign buf_from_eng = rsp_store;
  assign buf_widx     = rsp_store ? rlen_q[IW-1:0] : wptr_q[IW-1:0];

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    wptr_d   = wptr_q;
    sptr_d   = sptr_q;
    rptr_d   = rptr_q;
    rlen_d   = rlen_q;
    canned_d = canned_q;
    vhold_d  = crdy_hit || go_hit;
    abort_d  = cancel_hit;
    if (crdy_hit) begin
      st_d     = ST_READY;
      wptr_d   = '0;
      sptr_d   = '0;
      rptr_d   = '0;
      rlen_d   = '0;
      canned_d = 1'b0;
    end else begin
      case (st_q)
        ST_READY, ST_RECV: begin
          if (go_hit) begin
            st_d   = ST_EXEC;
            sptr_d = '0;
            rlen_d = '0;
          end else if (host_acc) begin
            wptr_d = wptr_q + ONE_C;
            st_d   = ST_RECV;
          end
        end
        ST_EXEC: begin
          if (cmd_fire) begin
            sptr_d = sptr_q + ONE_C;
          end
          if (cancel_hit) begin
            st_d     = ST_DONE;
            canned_d = 1'b1;
            rlen_d   = CANCEL_C;
            rptr_d   = '0;
          end else if (rsp_fire) begin
            if (rlen_q < DEPTH_C) begin
              rlen_d = rlen_q + ONE_C;
            end
            if (eng_rsp_last) begin
              st_d   = ST_DONE;
              rptr_d = '0;
            end
          end
        end
        ST_DONE: begin
          if (retry_hit) begin
            rptr_d = '0;
          end else if (rd_hit) begin
            rptr_d = rptr_q + ONE_C;
          end
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wptr_q   <= '0;
      sptr_q   <= '0;
      rptr_q   <= '0;
      rlen_q   <= '0;
      canned_q <= 1'b0;
      vhold_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      wptr_q   <= wptr_d;
      sptr_q   <= sptr_d;
      rptr_q   <= rptr_d;
      rlen_q   <= rlen_d;
      canned_q <= canned_d;
      vhold_q  <= vhold_d;
      abort_q  <= abort_d;
    end
  end

  assign st        = st_q;
  assign wptr      = wptr_q;
  assign sptr      = sptr_q;
  assign rptr      = rptr_q;
  assign rsp_len   = rlen_q;
  assign canned    = canned_q;
  assign vhold     = vhold_q;
  assign abort_pls = abort_q;

endmodule

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl #(
  parameter int          DEPTH     = 64,
  parameter int          AW        = 12,
  parameter logic [31:0] CANCEL_RC = 32'h0000_0908,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          eng_cmd_valid,
  input  logic          eng_cmd_ready,
  output logic [7:0]    eng_cmd_data,
  output logic          eng_cmd_last,
  input  logic          eng_rsp_valid,
  output logic          eng_rsp_ready,
  input  logic [7:0]    eng_rsp_data,
  input  logic          eng_rsp_last,
  output logic          eng_abort
);
  import cmdrsp_pkg::*;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // Address decode
  logic hit_sts, hit_xsts, hit_data, hit_bclo, hit_bchi;
  assign hit_sts  = (bus_addr == AW'(A_STS));
  assign hit_xsts = (bus_addr == AW'(A_XSTS));
  assign hit_bclo = (bus_addr == AW'(A_BC_LO));
  assign hit_bchi = (bus_addr == AW'(A_BC_HI));
  assign hit_data = (bus_addr == AW'(A_DATA)) || (bus_addr == AW'(A_XDATA));

  logic req_crdy, req_go, req_retry, req_cancel, host_we, host_re;
  assign req_crdy   = bus_wr && hit_sts && bus_wdata[B_CRDY];
  assign req_go     = bus_wr && hit_sts && bus_wdata[B_GO];
  assign req_retry  = bus_wr && hit_sts && bus_wdata[B_RETRY];
  assign req_cancel = bus_wr && hit_xsts && bus_wdata[0];
  assign host_we    = bus_wr && hit_data;
  assign host_re    = bus_rd && hit_data;

  cr_state_e     st;
  logic [CW-1:0] wptr, sptr, rptr, rsp_len;
  logic          canned, vhold, expect_more, host_acc, flush;
  logic          buf_we, buf_from_eng;
  logic [IW-1:0] buf_widx;
  logic [7:0]    buf_wdata, rd_byte_buf;

  cmdrsp_seq #(.DEPTH(DEPTH)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .req_crdy     (req_crdy),
    .req_go       (req_go),
    .req_retry    (req_retry),
    .req_cancel   (req_cancel),
    .host_we      (host_we),
    .host_re      (host_re),
    .expect_more  (expect_more),
    .eng_cmd_ready(eng_cmd_ready),
    .eng_rsp_valid(eng_rsp_valid),
    .eng_rsp_last (eng_rsp_last),
    .st           (st),
    .wptr         (wptr),
    .sptr         (sptr),
    .rptr         (rptr),
    .rsp_len      (rsp_len),
    .canned       (canned),
    .vhold        (vhold),
    .abort_pls    (eng_abort),
    .host_acc     (host_acc),
    .flush        (flush),
    .buf_we       (buf_we),
    .buf_from_eng (buf_from_eng),
    .buf_widx     (buf_widx),
    .cmd_valid    (eng_cmd_valid),
    .cmd_last     (eng_cmd_last),
    .rsp_ready    (eng_rsp_ready)
  );

  cmdrsp_lenparse #(.CW(CW)) len_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr        (flush),
    .byte_we    (host_acc),
    .byte_idx   (wptr),
    .byte_in    (bus_wdata),
    .expect_more(expect_more)
  );

  assign buf_wdata = buf_from_eng ? eng_rsp_data : bus_wdata;

  cmdrsp_buf #(.DEPTH(DEPTH)) buf_i (
    .clk    (clk),
    .we     (buf_we),
    .widx   (buf_widx),
    .wdata  (buf_wdata),
    .ridx_a (rptr[IW-1:0]),
    .rdata_a(rd_byte_buf),
    .ridx_b (sptr[IW-1:0]),
    .rdata_b(eng_cmd_data)
  );

  // Read-side views
  logic        dav, exp_flag;
  logic [7:0]  sts_byte, data_byte;
  logic [15:0] burst;

  assign dav      = (st == ST_DONE) && (rptr < rsp_len);
  assign exp_flag = (st == ST_RECV) && expect_more;

  always_comb begin
    sts_byte          = '0;
    sts_byte[B_VALID] = !vhold;
    sts_byte[B_CRDY]  = (st == ST_READY);
    sts_byte[B_DAV]   = dav;
    sts_byte[B_EXP]   = exp_flag;
    sts_byte[B_STDN]  = 1'b1;
  end

  always_comb begin
    case (st)
      ST_READY, ST_RECV: burst = 16'(DEPTH) - 16'(wptr);
      ST_DONE:           burst = 16'(rsp_len) - 16'(rptr);
      default:           burst = '0;
    endcase
  end

  always_comb begin
    if (!dav) begin
      data_byte = 8'h00;
    end else if (canned) begin
      data_byte = cancel_byte(32'(rptr), CANCEL_RC);
    end else begin
      data_byte = rd_byte_buf;
    end
  end

  always_comb begin
    if (hit_sts) begin
      bus_rdata = sts_byte;
    end else if (hit_bclo) begin
      bus_rdata = burst[7:0];
    end else if (hit_bchi) begin
      bus_rdata = burst[15:8];
    end else if (hit_xsts) begin
      bus_rdata = XSTS_FAMILY;
    end else if (hit_data) begin
      bus_rdata = data_byte;
    end else begin
      bus_rdata = 8'h00;
    end
  end

endmodule

// File: rtl/cmdrsp_ctrl_chk.sv
module cmdrsp_ctrl_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 12,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n_s,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [AW-1:0]         bus_addr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic                  eng_cmd_valid,
  input logic                  eng_abort,
  input cmdrsp_pkg::cr_state_e st,
  input logic [CW-1:0]         wptr,
  input logic [CW-1:0]         rptr,
  input logic [CW-1:0]         rsp_len,
  input logic                  vhold,
  input logic                  expect_more
);
  import cmdrsp_pkg::*;

  logic wr_go, wr_cancel;
  assign wr_go     = bus_wr && bus_addr == AW'(A_STS) && bus_wdata[B_GO] && !bus_wdata[B_CRDY];
  assign wr_cancel = bus_wr && bus_addr == AW'(A_XSTS) && bus_wdata[0];

  a_r3_wptr_bound: assert property (@(posedge clk) disable iff (!rst_n_s)
    wptr <= CW'(DEPTH));

  a_r4_go_held_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_RECV && expect_more && wr_go) |=> (st == ST_RECV));

  a_r5_cmd_only_exec: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_cmd_valid |-> (st == ST_EXEC));

  a_r6_rptr_bound: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_DONE) |-> (rptr <= rsp_len));

  a_r8_cancel_abort: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_EXEC && wr_cancel) |=> (eng_abort && st == ST_DONE && rsp_len == CW'(CANCEL_LEN)));

  a_r9_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_DONE && wr_cancel && !bus_wr_other_sts && !bus_rd) |=> (!eng_abort && $stable(rptr) && st == ST_DONE));

  a_r10_valid_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vhold && bus_addr == AW'(A_STS)) |-> !bus_rdata[B_VALID]);

  // helper: a cancel write can never also be a status write, kept explicit
  logic bus_wr_other_sts;
  assign bus_wr_other_sts = 1'b0;

endmodule

bind cmdrsp_ctrl cmdrsp_ctrl_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .eng_cmd_valid(eng_cmd_valid),
  .eng_abort    (eng_abort),
  .st           (st),
  .wptr         (wptr),
  .rptr         (rptr),
  .rsp_len      (rsp_len),
  .vhold        (vhold),
  .expect_more  (expect_more)
);

// File: tb/cmdrsp_ctrl_tb.sv
module cmdrsp_ctrl_tb_top;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       eng_cmd_valid, eng_cmd_last, eng_rsp_ready, eng_abort;
  logic [7:0] eng_cmd_data;
  logic       eng_cmd_ready = 1'b1;
  logic       eng_rsp_valid = 1'b0, eng_rsp_last = 1'b0;
  logic [7:0] eng_rsp_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  cmdrsp_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_data(eng_cmd_data), .eng_cmd_last(eng_cmd_last),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
    .eng_rsp_data(eng_rsp_data), .eng_rsp_last(eng_rsp_last),
    .eng_abort(eng_abort)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // Engine-side monitors
  logic [7:0] cap [256];
  int cap_n = 0, cap_last_n = 0, abort_n = 0;
  always @(posedge clk) begin
    if (eng_cmd_valid && eng_cmd_ready) begin
      cap[cap_n & 255] <= eng_cmd_data;
      cap_n <= cap_n + 1;
      if (eng_cmd_last) cap_last_n <= cap_last_n + 1;
    end
    if (eng_abort) abort_n <= abort_n + 1;
  end

  logic [7:0] cmd_a [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A,
                             8'h11, 8'h22, 8'h33, 8'h44};
  logic [7:0] cancel_rsp [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A,
                                  8'h00, 8'h00, 8'h09, 8'h08};

  function automatic logic [7:0] rsp_pat(input int i);
    return 8'(8'h5A + 3 * i);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [11:0] a, input int exp);
    logic [7:0] v;
    bus_read(a, v);
    check(req, int'(v), exp);
  endtask

  task automatic read_burst(output int bc);
    logic [7:0] lo, hi;
    bus_read(12'h019, lo);
    bus_read(12'h01A, hi);
    bc = int'({hi, lo});
  endtask

  task automatic eng_send(input int n, input bit with_last);
    for (int i = 0; i < n; i++) begin
      eng_rsp_valid = 1'b1; eng_rsp_data = rsp_pat(i);
      eng_rsp_last = with_last && (i == n - 1);
      #1;
      while (!eng_rsp_ready) begin
        @(negedge clk); #1;
      end
      @(negedge clk);
    end
    eng_rsp_valid = 1'b0; eng_rsp_last = 1'b0;
  endtask

  task automatic wait_cmd(input int target);
    for (int i = 0; i < 100 && cap_n < target; i++) @(negedge clk);
  endtask

  task automatic load_cmd_a();
    for (int i = 0; i < 10; i++) bus_write((i % 2) ? 12'h080 : 12'h024, cmd_a[i]);
  endtask

  task automatic t_reset();
    int bc;
    expect_reg("R1 status", 12'h018, 8'h84);
    read_burst(bc);
    check("R1 burst", bc, 0);
    expect_reg("R1 xstatus", 12'h01B, 8'h04);
    expect_reg("R9 cancel bit idle", 12'h01B, 8'h04);
  endtask

  task automatic t_ready();
    int bc;
    bus_write(12'h018, 8'h40);
    expect_reg("R10 valid low after cmd-ready", 12'h018, 8'h44);
    expect_reg("R2 ready state", 12'h018, 8'hC4);
    read_burst(bc);
    check("R2 burst=depth", bc, DEPTH);
  endtask

  task automatic t_load();
    int bc;
    for (int i = 0; i < 3; i++) bus_write(12'h024, cmd_a[i]);
    expect_reg("R4 expect during header", 12'h018, 8'h8C);
    read_burst(bc);
    check("R3 burst free space", bc, DEPTH - 3);
    bus_write(12'h018, 8'h20);
    expect_reg("R4 go ignored while expect", 12'h018, 8'h8C);
    for (int i = 3; i < 10; i++) bus_write(12'h080, cmd_a[i]);
    expect_reg("R4 expect cleared", 12'h018, 8'h84);
    bus_write(12'h024, 8'h55);
    read_burst(bc);
    check("R3 extra byte dropped", bc, DEPTH - 10);
  endtask

  task automatic t_exec();
    int base, lbase, bc;
    logic [7:0] v;
    base = cap_n; lbase = cap_last_n;
    bus_write(12'h018, 8'h20);
    expect_reg("R10 valid low after go", 12'h018, 8'h04);
    wait_cmd(base + 10);
    check("R5 cmd count", cap_n - base, 10);
    check("R5 last marker", cap_last_n - lbase, 1);
    for (int i = 0; i < 10; i++) check("R5 cmd byte", int'(cap[(base + i) & 255]), int'(cmd_a[i]));
    bus_write(12'h018, 8'h40);
    expect_reg("R2 cmd-ready ignored in exec", 12'h018, 8'h84);
    eng_send(12, 1'b1);
    expect_reg("R6 data-available", 12'h018, 8'h94);
    read_burst(bc);
    check("R6 burst remaining", bc, 12);
    for (int i = 0; i < 12; i++) begin
      bus_read((i % 2) ? 12'h080 : 12'h024, v);
      check("R6 rsp byte", int'(v), int'(rsp_pat(i)));
    end
    expect_reg("R6 drained", 12'h018, 8'h84);
  endtask

  task automatic t_retry_and_idle_cancel();
    int bc, ab;
    logic [7:0] v;
    bus_write(12'h018, 8'h02);
    bus_read(12'h024, v);
    check("R7 replay first byte", int'(v), int'(rsp_pat(0)));
    read_burst(bc);
    check("R7 burst after replay", bc, 11);
    ab = abort_n;
    bus_write(12'h01B, 8'h01);
    @(negedge clk);
    check("R9 no abort", abort_n - ab, 0);
    expect_reg("R9 status unchanged", 12'h018, 8'h94);
    bus_read(12'h080, v);
    check("R9 readout position kept", int'(v), int'(rsp_pat(1)));
  endtask

  task automatic t_cancel();
    int base, ab, bc;
    logic [7:0] v;
    bus_write(12'h018, 8'h40);
    load_cmd_a();
    base = cap_n;
    bus_write(12'h018, 8'h20);
    wait_cmd(base + 10);
    ab = abort_n;
    bus_write(12'h01B, 8'h01);
    @(negedge clk);
    check("R8 abort pulse", abort_n - ab, 1);
    expect_reg("R8 status after cancel", 12'h018, 8'h94);
    read_burst(bc);
    check("R8 cancel length", bc, 10);
    for (int i = 0; i < 10; i++) begin
      bus_read(12'h024, v);
      check("R8 cancel byte", int'(v), int'(cancel_rsp[i]));
    end
  endtask

  task automatic t_race();
    int base, ab, bc;
    logic [7:0] v;
    bus_write(12'h018, 8'h40);
    load_cmd_a();
    base = cap_n;
    bus_write(12'h018, 8'h20);
    wait_cmd(base + 10);
    eng_send(2, 1'b0);
    ab = abort_n;
    bus_wr = 1'b1; bus_addr = 12'h01B; bus_wdata = 8'h01;
    eng_rsp_valid = 1'b1; eng_rsp_last = 1'b1; eng_rsp_data = 8'hEE;
    @(negedge clk);
    bus_wr = 1'b0; eng_rsp_valid = 1'b0; eng_rsp_last = 1'b0;
    @(negedge clk);
    check("R11 abort on race", abort_n - ab, 1);
    read_burst(bc);
    check("R11 cancelled length", bc, 10);
    for (int i = 0; i < 10; i++) begin
      bus_read(12'h080, v);
      check("R11 cancelled byte", int'(v), int'(cancel_rsp[i]));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ready();
    t_load();
    t_exec();
    t_retry_and_idle_cancel();
    t_cancel();
    t_race();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule